// File: doc/BRIEF.md
# Open-Row DRAM Access Controller

This block sits between a single-word request port (valid/ready) and a DRAM whose row and column addresses share one set of address pins. Each request address is split into a row field (upper bits) and a column field (lower bits). The controller drives the active-low row strobe, column strobe and write enable, and multiplexes the two address fields onto the shared pins. Each access moves one data word.

After a row has been opened, the controller keeps the row strobe low and records which row is open. A later access to the same row is issued as a column strobe only, with no row phase. An access to a different row first raises the row strobe for a precharge interval, then opens the new row. A close request from outside, for example from a refresh scheduler, shuts the open row. Precharge time, row-to-column delay and column latency are parameters counted in clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row field is `req_addr[ROW_W+COL_W-1:COL_W]` and the column field is `req_addr[COL_W-1:0]`. Both are zero-extended to the width of `dram_addr`. The row field is on `dram_addr` at the clock edge where `dram_ras_n` falls, and the column field is on it while `dram_cas_n` is low.
- R2: A request accepted while no row is open activates its row at once. The controller is busy for T_RCD + T_CAS cycles, counted from the accepting edge until `req_ready` returns high.
- R3: A request to the open row causes no new fall of `dram_ras_n`, and `dram_ras_n` stays low throughout. The controller is busy for T_CAS cycles.
- R4: A request to a different row than the open one raises `dram_ras_n` for T_PRE cycles, then activates the new row. The controller is busy for T_PRE + T_RCD + T_CAS cycles.
- R5: On a read, `rsp_valid` is high for exactly one cycle. It rises at the edge that ends the column phase, and `rsp_rdata` then holds the addressed word.
- R6: On a write, `dram_we_n` is low and `dram_dq_oe` is high during the column phase, with the write data on `dram_dq_out`. A later read of that address returns the data.
- R7: When `close_row` is high while the controller is idle, `dram_ras_n` is high from the next cycle on, and `req_ready` is low while `close_row` is high. The next access to the former row is treated as a first access (R2).
- R8: `dram_cas_n` is low only while `dram_ras_n` is low, and `dram_we_n` is low only while `dram_cas_n` is low.
- R9: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row field in upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data |
| close_row | input | 1 | Close the open row |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_dq_out | output | DATA_W | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The delay of each result depends on the access class: T_CAS cycles for an open-row hit, T_RCD + T_CAS for a first access, and T_PRE + T_RCD + T_CAS for a row conflict. The bench counts falling edges from the accepting edge. For a read it stops at the one-cycle `rsp_valid` pulse, and for a write it stops when `req_ready` returns. It compares that count with the value its own open-row model predicts, and then checks that the pulse is gone one cycle later. A behavioural DRAM in the bench counts row activations and latches the row and column it sees. From these records the bench checks that hits skip the row phase and that the address fields land on the right strobe. After `close_row`, the bench checks the strobe and `req_ready` one cycle later, then the latency of the next access.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_PRE  = 2'd1,
      S_ACT  = 2'd2,
      S_COL  = 2'd3
   } fpm_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
   parameter int ROW_W = 4,
   parameter int COL_W = 4,
   parameter int MUX_W = 4
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   output logic [MUX_W-1:0]       row_m,
   output logic [MUX_W-1:0]       col_m,
   output logic [ROW_W-1:0]       row_f
);
   assign row_f = addr[ROW_W+COL_W-1:COL_W];

   generate
      if (MUX_W > ROW_W) begin : g_row_pad
         assign row_m = {{(MUX_W-ROW_W){1'b0}}, addr[ROW_W+COL_W-1:COL_W]};
      end else begin : g_row_full
         assign row_m = addr[ROW_W+COL_W-1:COL_W];
      end
      if (MUX_W > COL_W) begin : g_col_pad
         assign col_m = {{(MUX_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      end else begin : g_col_full
         assign col_m = addr[COL_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic             clr,
   input  logic [ROW_W-1:0] set_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             hit,
   output logic             open_vld
);
   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_row <= '0;
         open_vld <= 1'b0;
      end else if (clr) begin
         open_vld <= 1'b0;
      end else if (set) begin
         open_row <= set_row;
         open_vld <= 1'b1;
      end
   end

   assign hit = open_vld && (cmp_row == open_row);

   // R3: a row that has just been opened is the row that gets compared afterwards
   a_r3_open_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> (open_vld && open_row == $past(set_row)));
endmodule

// File: rtl/fpm_timer.sv
module fpm_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   a_r2_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
   import fpm_pkg::*;
#(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 4,
   parameter int DATA_W = 8,
   parameter int T_PRE  = 2,
   parameter int T_RCD  = 2,
   parameter int T_CAS  = 2,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              close_row,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [MUX_W-1:0]  dram_addr,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int T_MAX = max2(max2(T_PRE, T_RCD), T_CAS);
   localparam int CNT_W = $clog2(T_MAX + 1);

   generate
      if (T_PRE < 1 || T_RCD < 1 || T_CAS < 1) begin : g_bad_timing
         $error("fpm_dram_ctrl: timing parameters must be at least 1");
      end
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("fpm_dram_ctrl: widths must be at least 1");
      end
   endgenerate

   fpm_state_t       state, nstate;
   logic [MUX_W-1:0] row_q, col_q;
   logic [ROW_W-1:0] rowf_q;
   logic             wr_q, pend;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic             rsp_q;

   logic [MUX_W-1:0] req_row_m, req_col_m;
   logic [ROW_W-1:0] req_row_f;
   logic             hit, open_vld;
   logic             trk_set, trk_clr;
   logic [ROW_W-1:0] set_row;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             accept;

   fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_split (
      .addr  (req_addr),
      .row_m (req_row_m),
      .col_m (req_col_m),
      .row_f (req_row_f)
   );

   fpm_row_tracker #(.ROW_W(ROW_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (trk_set),
      .clr      (trk_clr),
      .set_row  (set_row),
      .cmp_row  (req_row_f),
      .hit      (hit),
      .open_vld (open_vld)
   );

   fpm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   assign req_ready = (state == S_IDLE) && !close_row;
   assign set_row   = (state == S_IDLE) ? req_row_f : rowf_q;

   always_comb begin
      nstate   = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      trk_set  = 1'b0;
      trk_clr  = 1'b0;
      accept   = 1'b0;
      unique case (state)
         S_IDLE: begin
            if (close_row) begin
               if (open_vld) begin
                  nstate   = S_PRE;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_PRE - 1);
                  trk_clr  = 1'b1;
               end
            end else if (req_valid) begin
               accept = 1'b1;
               if (hit) begin
                  nstate   = S_COL;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_CAS - 1);
               end else if (open_vld) begin
                  nstate   = S_PRE;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_PRE - 1);
                  trk_clr  = 1'b1;
               end else begin
                  nstate   = S_ACT;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_RCD - 1);
                  trk_set  = 1'b1;
               end
            end
         end
         S_PRE: begin
            if (tmr_zero) begin
               if (pend) begin
                  nstate   = S_ACT;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_RCD - 1);
                  trk_set  = 1'b1;
               end else begin
                  nstate = S_IDLE;
               end
            end
         end
         S_ACT: begin
            if (tmr_zero) begin
               nstate   = S_COL;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_CAS - 1);
            end
         end
         S_COL: begin
            if (tmr_zero) nstate = S_IDLE;
         end
         default: nstate = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         rowf_q  <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         pend    <= 1'b0;
         rsp_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state <= nstate;
         rsp_q <= 1'b0;
         if (accept) begin
            row_q   <= req_row_m;
            col_q   <= req_col_m;
            rowf_q  <= req_row_f;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            pend    <= 1'b1;
         end else if (state == S_COL && tmr_zero) begin
            pend <= 1'b0;
            if (!wr_q) begin
               rsp_q   <= 1'b1;
               rdata_q <= dram_dq_in;
            end
         end
      end
   end

   assign dram_ras_n  = !((state == S_ACT) || (state == S_COL) || (state == S_IDLE && open_vld));
   assign dram_cas_n  = (state != S_COL);
   assign dram_we_n   = !((state == S_COL) && wr_q);
   assign dram_dq_oe  = (state == S_COL) && wr_q;
   assign dram_dq_out = wdata_q;
   assign dram_addr   = (state == S_COL) ? col_q : row_q;
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;

   // R8: column strobe only inside an open row, write enable only with column strobe
   a_r8_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);
   a_r8_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_cas_n);
   // R1: column address held steady through the column phase
   a_r1_col_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
   // R5: read strobe lasts one cycle
   a_r5_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R7: close while idle leaves the row strobe high next cycle
   a_r7_close_raises_ras: assert property (@(posedge clk) disable iff (!rst_n)
      (close_row && state == S_IDLE) |=> dram_ras_n);
   // R3: accepted hit keeps the row strobe low into the column phase
   a_r3_hit_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit) |=> (!dram_ras_n && !dram_cas_n));
   // R6: write data driven while writing
   a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> dram_dq_oe);
endmodule

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;
   localparam int ROW_W  = 4;
   localparam int COL_W  = 4;
   localparam int DATA_W = 8;
   localparam int T_PRE  = 2;
   localparam int T_RCD  = 2;
   localparam int T_CAS  = 2;
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int L_HIT  = T_CAS;
   localparam int L_COLD = T_RCD + T_CAS;
   localparam int L_CONF = T_PRE + T_RCD + T_CAS;

   // vector: {write, addr[7:0], data[7:0], class[1:0]}  class 0=hit 1=cold 2=conflict
   localparam int NV = 9;
   localparam logic [18:0] VEC [NV] = '{
      {1'b1, 8'h12, 8'hA5, 2'd1},
      {1'b1, 8'h13, 8'h3C, 2'd0},
      {1'b0, 8'h12, 8'hA5, 2'd0},
      {1'b0, 8'h13, 8'h3C, 2'd0},
      {1'b1, 8'h57, 8'hC3, 2'd2},
      {1'b0, 8'h12, 8'hA5, 2'd2},
      {1'b0, 8'h57, 8'hC3, 2'd2},
      {1'b1, 8'h50, 8'h0F, 2'd0},
      {1'b0, 8'h50, 8'h0F, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, close_row = 1'b0;
   logic [ROW_W+COL_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [DATA_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
   logic [MUX_W-1:0] dram_addr;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .close_row(close_row),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   // behavioural DRAM
   logic [DATA_W-1:0] mem [2**ROW_W][2**COL_W];
   logic [ROW_W-1:0] m_row;
   logic [COL_W-1:0] m_col;
   logic prev_ras = 1'b1, prev_cas = 1'b1;
   int acts = 0;

   initial begin
      for (int r = 0; r < 2**ROW_W; r++)
         for (int c = 0; c < 2**COL_W; c++) mem[r][c] = '0;
      m_row = '0;
      m_col = '0;
   end

   always @(posedge clk) begin
      prev_ras <= dram_ras_n;
      prev_cas <= dram_cas_n;
      if (!dram_ras_n && prev_ras) begin
         m_row <= dram_addr[ROW_W-1:0];
         acts  <= acts + 1;
      end
      if (!dram_cas_n && prev_cas) m_col <= dram_addr[COL_W-1:0];
      if (!dram_cas_n && !dram_we_n && dram_dq_oe)
         mem[m_row][dram_addr[COL_W-1:0]] <= dram_dq_out;
   end

   assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[m_row][dram_addr[COL_W-1:0]] : '0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [7:0] addr, input logic [7:0] data,
                         output int lat, output logic [DATA_W-1:0] rd);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      req_wdata = data;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      rd  = '0;
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         lat++;
         if (!wr && rsp_valid) begin rd = rsp_rdata; break; end
         if (wr && req_ready) break;
      end
   endtask

   initial begin
      for (int n = 0; n < 20000; n++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int lat, a0, exp_lat;
      logic [DATA_W-1:0] rd;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(dram_ras_n && dram_cas_n && dram_we_n, "R9 strobes", {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
      check(req_ready && !rsp_valid, "R9 ready/rsp", {req_ready, rsp_valid}, 2'b10);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [18:0] v;
         v = VEC[i];
         exp_lat = (v[1:0] == 2'd0) ? L_HIT : (v[1:0] == 2'd1) ? L_COLD : L_CONF;
         a0 = acts;
         access(v[18], v[17:10], v[9:2], lat, rd);
         // R2 cold / R3 hit / R4 conflict latency
         check(lat == exp_lat, (v[1:0] == 0) ? "R3 hit latency" : (v[1:0] == 1) ? "R2 cold latency" : "R4 conflict latency", lat, exp_lat);
         check((acts - a0) == ((v[1:0] == 2'd0) ? 0 : 1), "R3 activations", acts - a0, (v[1:0] == 2'd0) ? 0 : 1);
         if (!v[18]) begin
            check(rd == v[9:2], "R5/R6 read data", rd, v[9:2]);
            @(negedge clk);
            check(!rsp_valid, "R5 single pulse", rsp_valid, 0);
         end
         if (i == 6) begin
            // R1: row and column fields reached the DRAM on the right strobes
            check(m_row == 4'h5, "R1 row field", m_row, 5);
            check(m_col == 4'h7, "R1 col field", m_col, 7);
         end
      end

      // R7: close the open row
      @(negedge clk);
      close_row = 1'b1;
      @(negedge clk);
      check(dram_ras_n == 1'b1, "R7 ras high after close", dram_ras_n, 1);
      check(req_ready == 1'b0, "R7 not ready while closing", req_ready, 0);
      repeat (3) @(negedge clk);
      check(dram_ras_n == 1'b1, "R7 row stays closed", dram_ras_n, 1);
      close_row = 1'b0;
      a0 = acts;
      access(1'b0, 8'h50, 8'h00, lat, rd);
      check(lat == L_COLD, "R7 reopen is cold", lat, L_COLD);
      check(acts - a0 == 1, "R7 reopen activates", acts - a0, 1);
      check(rd == 8'h0F, "R7 data after reopen", rd, 8'h0F);

      // R6: write strobes during a column phase
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h5A; req_wdata = 8'h66;
      @(negedge clk);
      req_valid = 1'b0;
      check(!dram_we_n && dram_dq_oe && dram_dq_out == 8'h66, "R6 write strobes",
            {dram_we_n, dram_dq_oe, dram_dq_out}, {1'b0, 1'b1, 8'h66});
      repeat (4) @(negedge clk);
      access(1'b0, 8'h5A, 8'h00, lat, rd);
      check(rd == 8'h66, "R6 write readback", rd, 8'h66);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule